// File: doc/BRIEF.md
# Seed and Security Code Command Handler

This block sits behind a byte-level serial slave front end and serves three security commands. The front end hands over the command byte, each byte the master writes, a pulse each time the master has taken a byte it read, and the START and STOP events. The handler returns the byte that goes out next on the bus.

A master can store a 64-bit seed with a block write and read the stored seed back with a block read. It can also read a 64-bit rolling code with a block read. The code comes from a 63-bit LFSR that is loaded from the seed mixed with a fixed 16-bit vendor identifier. The identifier is a parameter and no command can read or write it. Every code read moves the generator forward, so two reads in a row return different codes.

A seed write reaches storage only at STOP, and only when the transfer was well formed and write protect was low. After a write is stored, a busy flag stands for a fixed number of cycles to model the internal write time.

Top module: `seccmd_handler`

## Requirements
- R1: A transfer with command 0xC0, a first data byte of 0x08 and exactly 8 further bytes stores those bytes as the seed at STOP, first byte as bits 63:56. Nothing is stored before STOP.
- R2: A seed write is discarded when `wp_i` is high in the STOP cycle. The stored seed keeps its value and `busy_o` stays low.
- R3: A seed write is discarded when its length byte is not 0x08, or when it carries fewer or more than 8 seed bytes.
- R4: `busy_o` rises in the cycle after a stored write and stays high for exactly BUSY_CYCLES cycles. A seed write whose STOP falls while `busy_o` is high is discarded.
- R5: With command 0xC1 the outgoing bytes are 0x08 first, then the 8 seed bytes from bits 63:56 down to bits 7:0. Past the last seed byte the outgoing byte is 0x00.
- R6: With command 0xC3 the outgoing bytes are 0x08 first, then 8 code bytes from the most significant down. Code bit 63 is always 1 and bits 62:0 are the generator state.
- R7: The generator is loaded with bits 62:0 of (seed XOR the vendor ID repeated four times), or with 1 if that value is zero. One step is s <= {s[61:0], s[62]^s[61]}. Each accepted 0xC3 command advances it STEPS steps before the read, so successive codes differ.
- R8: After reset the stored seed is zero, `busy_o` is low and the generator holds the load value of a zero seed.
- R9: Any other command byte gives 0x00 outgoing bytes and ignores incoming bytes. A START or repeated START, and any new command, returns the read position to the length byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wp_i | input | 1 | Write protect; blocks seed storage when high |
| xfer_start_i | input | 1 | One-cycle pulse on START or repeated START |
| cmd_valid_i | input | 1 | One-cycle pulse: command byte received |
| cmd_byte_i | input | 8 | Command byte |
| rx_valid_i | input | 1 | One-cycle pulse: a written byte received after the command |
| rx_byte_i | input | 8 | Received byte |
| stop_i | input | 1 | One-cycle pulse on STOP |
| tx_next_i | input | 1 | One-cycle pulse: master took the current outgoing byte |
| tx_byte_o | output | 8 | Byte to send next |
| busy_o | output | 1 | Internal write in progress |

## Verification
The bench builds the block with the full 64-bit seed, 64 generator steps per code read and the default vendor ID. BUSY_CYCLES is reduced to 40, which is still longer than one complete seed write on the byte interface. With that value a second write can place its STOP inside the busy window of the first. The busy length can then be counted exactly without a long wait, and the generator values can be predicted across many random seeds and back-to-back code reads.

// File: rtl/seccmd_pkg.sv
// Shared command codes and operation type for the seed/code handler.
package seccmd_pkg;
    localparam logic [7:0] CMD_SEED_WR = 8'hC0;
    localparam logic [7:0] CMD_SEED_RD = 8'hC1;
    localparam logic [7:0] CMD_CODE_RD = 8'hC3;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SEED_WR = 2'd1,
        OP_SEED_RD = 2'd2,
        OP_CODE_RD = 2'd3
    } op_e;
endpackage

// File: rtl/seccmd_seed_store.sv
// Seed staging, commit and busy timer.
// Assumes: one-cycle strobes from the front end; wr_sel_i holds during the whole write.
module seccmd_seed_store #(
    parameter int SEED_W      = 64,
    parameter int BUSY_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel_i,
    input  logic              cmd_valid_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic [SEED_W-1:0] seed_o,
    output logic              commit_o,
    output logic              busy_o
);
    localparam int NBYTES = SEED_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 2);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBYTES + 1);

    logic [CNT_W-1:0]  rx_cnt;
    logic              len_ok;
    logic              over;
    logic [SEED_W-1:0] stage;
    logic [SEED_W-1:0] seed_q;
    logic [BUSY_W-1:0] busy_cnt;

    assign commit_o = stop_i && wr_sel_i && len_ok && (rx_cnt == CNT_FULL)
                      && !over && !wp_i && (busy_cnt == '0);
    assign seed_o   = seed_q;
    assign busy_o   = (busy_cnt != '0);

    // Count received bytes, check the length byte and shift seed bytes in.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_valid_i || stop_i) begin
            rx_cnt <= '0;
            len_ok <= 1'b0;
            over   <= 1'b0;
        end else if (rx_valid_i && wr_sel_i) begin
            if (rx_cnt == '0)
                len_ok <= (rx_byte_i == 8'(NBYTES));
            else if (rx_cnt != CNT_FULL)
                stage <= {stage[SEED_W-9:0], rx_byte_i};
            if (rx_cnt == CNT_FULL)
                over <= 1'b1;
            else
                rx_cnt <= rx_cnt + 1'b1;
        end
    end

    // Store the staged seed when a valid write completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seed_q <= '0;
        else if (commit_o)
            seed_q <= stage;
    end

    // Hold busy for the internal write time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (commit_o)
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
        else if (busy_cnt != '0)
            busy_cnt <= busy_cnt - 1'b1;
    end
endmodule

// File: rtl/seccmd_codegen.sv
// Rolling code generator: a (SEED_W-1)-bit LFSR with taps on its top two bits.
// Assumes: SEED_W is a multiple of VID_W; load takes priority over advance.
module seccmd_codegen #(
    parameter int              SEED_W    = 64,
    parameter int              VID_W     = 16,
    parameter logic [VID_W-1:0] VENDOR_ID = 16'h5A3C,
    parameter int              STEPS     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              adv_i,
    output logic [SEED_W-2:0] state_o
);
    localparam int LW   = SEED_W - 1;
    localparam int REPS = SEED_W / VID_W;

    logic [LW-1:0] state_q;
    logic [LW-1:0] jump;

    function automatic logic [LW-1:0] fold(input logic [SEED_W-1:0] s);
        logic [SEED_W-1:0] m;
        m = s ^ {REPS{VENDOR_ID}};
        return (m[LW-1:0] == '0) ? LW'(1) : m[LW-1:0];
    endfunction

    function automatic logic [LW-1:0] step(input logic [LW-1:0] s);
        return {s[LW-2:0], s[LW-1] ^ s[LW-2]};
    endfunction

    // Unrolled STEPS-step jump computed in one cycle.
    always_comb begin
        jump = state_q;
        for (int k = 0; k < STEPS; k++)
            jump = step(jump);
    end

    // Load from the seed or advance by one jump.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= fold('0);
        else if (load_i)
            state_q <= fold(seed_i);
        else if (adv_i)
            state_q <= jump;
    end

    assign state_o = state_q;
endmodule

// File: rtl/seccmd_readout.sv
// Outgoing byte sequencer for block reads: length byte, then data MSB-first.
// Assumes: next_i pulses once per byte the master has taken.
module seccmd_readout
    import seccmd_pkg::*;
#(
    parameter int SEED_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              next_i,
    input  op_e               op_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic [SEED_W-2:0] state_i,
    output logic [7:0]        tx_byte_o,
    output logic [$clog2(SEED_W/8+2)-1:0] idx_o
);
    localparam int NBYTES = SEED_W / 8;
    localparam int IDX_W  = $clog2(NBYTES + 2);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBYTES + 1);

    logic [IDX_W-1:0]  idx_q;
    logic [SEED_W-1:0] word;
    int                off;

    // Advance the byte position, saturating past the last data byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            idx_q <= '0;
        else if (next_i && idx_q != IDX_END)
            idx_q <= idx_q + 1'b1;
    end

    // Select the byte at the current position.
    always_comb begin
        word      = (op_i == OP_SEED_RD) ? seed_i : {1'b1, state_i};
        off       = (NBYTES - int'(idx_q)) * 8;
        tx_byte_o = 8'h00;
        if (op_i == OP_SEED_RD || op_i == OP_CODE_RD) begin
            if (idx_q == '0)
                tx_byte_o = 8'(NBYTES);
            else if (idx_q != IDX_END)
                tx_byte_o = word[off +: 8];
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/seccmd_handler.sv
// Top: decodes the security command and ties storage, generator and readout together.
// Assumes: the front end gives one-cycle strobes and resolves bus-level ACK/NACK itself.
module seccmd_handler
    import seccmd_pkg::*;
#(
    parameter int               SEED_W      = 64,
    parameter int               VID_W       = 16,
    parameter logic [VID_W-1:0] VENDOR_ID   = 16'h5A3C,
    parameter int               STEPS       = 64,
    parameter int               BUSY_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_i,
    input  logic       xfer_start_i,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_byte_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       stop_i,
    input  logic       tx_next_i,
    output logic [7:0] tx_byte_o,
    output logic       busy_o
);
    localparam int IDX_W = $clog2(SEED_W / 8 + 2);

    op_e               op_q;
    logic              commit;
    logic [SEED_W-1:0] seed_q;
    logic [SEED_W-2:0] gen_state;
    logic [IDX_W-1:0]  tx_idx;
    logic              code_cmd;

    assign code_cmd = cmd_valid_i && (cmd_byte_i == CMD_CODE_RD);

    // Latch the decoded command; STOP ends it.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i)
            op_q <= OP_NONE;
        else if (cmd_valid_i) begin
            case (cmd_byte_i)
                CMD_SEED_WR: op_q <= OP_SEED_WR;
                CMD_SEED_RD: op_q <= OP_SEED_RD;
                CMD_CODE_RD: op_q <= OP_CODE_RD;
                default:     op_q <= OP_NONE;
            endcase
        end
    end

    seccmd_seed_store #(.SEED_W(SEED_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel_i   (op_q == OP_SEED_WR),
        .cmd_valid_i(cmd_valid_i),
        .rx_valid_i (rx_valid_i),
        .rx_byte_i  (rx_byte_i),
        .stop_i     (stop_i),
        .wp_i       (wp_i),
        .seed_o     (seed_q),
        .commit_o   (commit),
        .busy_o     (busy_o)
    );

    seccmd_codegen #(.SEED_W(SEED_W), .VID_W(VID_W), .VENDOR_ID(VENDOR_ID),
                     .STEPS(STEPS)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit),
        .seed_i (seed_q_next_unused_guard(commit, seed_q)),
        .adv_i  (code_cmd),
        .state_o(gen_state)
    );

    seccmd_readout #(.SEED_W(SEED_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(xfer_start_i || cmd_valid_i),
        .next_i   (tx_next_i),
        .op_i     (op_q),
        .seed_i   (seed_q),
        .state_i  (gen_state),
        .tx_byte_o(tx_byte_o),
        .idx_o    (tx_idx)
    );

    function automatic logic [SEED_W-1:0] seed_q_next_unused_guard(
        input logic c, input logic [SEED_W-1:0] s);
        return c ? u_store.stage : s;
    endfunction
endmodule

// File: rtl/seccmd_handler_chk.sv
// Assertion checker bound to seccmd_handler.
module seccmd_handler_chk
    import seccmd_pkg::*;
#(
    parameter int SEED_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              wp_i,
    input logic              busy_o,
    input logic [7:0]        tx_byte_o,
    input logic [$clog2(SEED_W/8+2)-1:0] tx_idx,
    input op_e               op,
    input logic [SEED_W-2:0] gen_state,
    input logic [SEED_W-1:0] seed
);
    AST_SEED_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seed) |-> $past(stop_i)); // R1
    AST_WP_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(wp_i)); // R2
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i)); // R4
    AST_LEN_BYTE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_SEED_RD || op == OP_CODE_RD) && tx_idx == '0) |-> (tx_byte_o == 8'(SEED_W/8))); // R5
    AST_CODE_TOP_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CODE_RD && tx_idx == 1) |-> tx_byte_o[7]); // R6
    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gen_state != '0); // R7
endmodule

bind seccmd_handler seccmd_handler_chk #(.SEED_W(SEED_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .wp_i     (wp_i),
    .busy_o   (busy_o),
    .tx_byte_o(tx_byte_o),
    .tx_idx   (tx_idx),
    .op       (op_q),
    .gen_state(gen_state),
    .seed     (seed_q)
);

// File: tb/seccmd_handler_bench.sv
module seccmd_handler_bench;
    localparam int               SEED_W = 64;
    localparam logic [15:0]      VID    = 16'h5A3C;
    localparam int               STEPS  = 64;
    localparam int               BUSY   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_i = 1'b0;
    logic       xfer_start_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [7:0] cmd_byte_i = 8'h00;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic       stop_i = 1'b0;
    logic       tx_next_i = 1'b0;
    logic [7:0] tx_byte_o;
    logic       busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [63:0] m_seed;
    logic [62:0] m_state;

    always #2 clk = ~clk;

    seccmd_handler #(.SEED_W(SEED_W), .VID_W(16), .VENDOR_ID(VID), .STEPS(STEPS),
                     .BUSY_CYCLES(BUSY)) u_seccmd_handler (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .xfer_start_i(xfer_start_i),
        .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i), .rx_valid_i(rx_valid_i),
        .rx_byte_i(rx_byte_i), .stop_i(stop_i), .tx_next_i(tx_next_i),
        .tx_byte_o(tx_byte_o), .busy_o(busy_o)
    );

    function automatic logic [62:0] b_load(input logic [63:0] s);
        logic [63:0] m;
        m = s ^ {4{VID}};
        return (m[62:0] == '0) ? 63'd1 : m[62:0];
    endfunction

    function automatic logic [62:0] b_adv(input logic [62:0] s);
        logic [62:0] t;
        t = s;
        for (int k = 0; k < STEPS; k++) t = {t[61:0], t[62] ^ t[61]};
        return t;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) xfer_start_i = 1'b1;
        @(negedge clk) xfer_start_i = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        pulse_start();
        cmd_valid_i = 1'b1; cmd_byte_i = c;
        @(negedge clk) cmd_valid_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk) rx_valid_i = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic tx_adv();
        @(negedge clk) tx_next_i = 1'b1;
        @(negedge clk) tx_next_i = 1'b0;
    endtask

    // Seed write with chosen length byte and number of data bytes.
    task automatic write_seed(input logic [63:0] s, input logic [7:0] len, input int nb);
        send_cmd(8'hC0);
        send_byte(len);
        for (int i = 0; i < nb; i++)
            send_byte((i < 8) ? s[63-8*i -: 8] : 8'($urandom));
        send_stop();
    endtask

    // Block read: command, repeated START, length byte and 8 data bytes.
    task automatic read_block(input logic [7:0] c, output logic [7:0] len, output logic [63:0] d);
        send_cmd(c);
        pulse_start();
        len = tx_byte_o;
        for (int i = 0; i < 8; i++) begin
            tx_adv();
            d[63-8*i -: 8] = tx_byte_o;
        end
        tx_adv();
        send_stop();
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic expect_code(input string req);
        logic [7:0]  l;
        logic [63:0] d;
        m_state = b_adv(m_state);
        read_block(8'hC3, l, d);
        check(req, l, 64'h08);
        check(req, d, {1'b1, m_state});
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  l;
        logic [63:0] d, s, c1;
        int          cnt;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_seed  = '0;
        m_state = b_load('0);

        // R8 reset state, R9 idle output
        check("R8 busy", busy_o, 0);
        check("R9 idle byte", tx_byte_o, 0);
        read_block(8'hC1, l, d);
        check("R5 len", l, 64'h08);
        check("R8 seed", d, 0);
        expect_code("R6 R8 first code");

        // R1 R4 R5 R7 random seeds
        for (int it = 0; it < 6; it++) begin
            s = {$urandom, $urandom};
            send_cmd(8'hC0);
            send_byte(8'h08);
            for (int i = 0; i < 8; i++) send_byte(s[63-8*i -: 8]);
            check("R1 no commit before stop", busy_o, 0);
            send_stop();
            cnt = 0;
            while (busy_o) begin cnt++; @(negedge clk); end
            check("R4 busy length", cnt, BUSY);
            m_seed = s; m_state = b_load(s);
            read_block(8'hC1, l, d);
            check("R1 R5 seed", d, m_seed);
            expect_code("R7 code a");
            c1 = {1'b1, m_state};
            expect_code("R7 code b");
            n_cmp++;
            if (c1 == {1'b1, m_state}) begin
                n_bad++;
                $display("FAIL R7 rolling: actual %h expected a different code", c1);
            end
        end

        // R2 write protect
        wp_i = 1'b1;
        write_seed(64'h1122334455667788, 8'h08, 8);
        check("R2 busy", busy_o, 0);
        wp_i = 1'b0;
        read_block(8'hC1, l, d);
        check("R2 seed kept", d, m_seed);

        // R3 wrong length byte, short and long payloads
        write_seed(64'hDEADBEEF01234567, 8'h07, 8);
        check("R3 len7 busy", busy_o, 0);
        write_seed(64'hDEADBEEF01234567, 8'h08, 7);
        check("R3 short busy", busy_o, 0);
        write_seed(64'hDEADBEEF01234567, 8'h08, 9);
        check("R3 long busy", busy_o, 0);
        read_block(8'hC1, l, d);
        check("R3 seed kept", d, m_seed);

        // R4 write landing inside the busy window is dropped
        write_seed(64'h0F0E0D0C0B0A0908, 8'h08, 8);
        m_seed = 64'h0F0E0D0C0B0A0908; m_state = b_load(m_seed);
        write_seed(64'hAAAA5555AAAA5555, 8'h08, 8);
        wait_idle();
        read_block(8'hC1, l, d);
        check("R4 second write dropped", d, m_seed);
        expect_code("R6 R7 after reload");

        // R7 zero load value falls back to 1
        write_seed({4{VID}}, 8'h08, 8);
        wait_idle();
        m_seed = {4{VID}}; m_state = 63'd1;
        expect_code("R7 zero fold");

        // R9 unknown command
        send_cmd(8'hC2);
        check("R9 unknown len", tx_byte_o, 0);
        tx_adv();
        check("R9 unknown data", tx_byte_o, 0);
        send_byte(8'h08);
        for (int i = 0; i < 8; i++) send_byte(8'h99);
        send_stop();
        check("R9 no write", busy_o, 0);

        // R5 past end, R9 restart returns to length byte
        send_cmd(8'hC1);
        pulse_start();
        for (int i = 0; i < 9; i++) tx_adv();
        check("R5 past end", tx_byte_o, 0);
        tx_adv();
        check("R5 saturated", tx_byte_o, 0);
        pulse_start();
        check("R9 restart len", tx_byte_o, 64'h08);
        tx_adv();
        check("R9 restart first", tx_byte_o, {56'd0, m_seed[63:56]});
        send_stop();
        check("R9 after stop", tx_byte_o, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule